// File: doc/BRIEF.md
# Non-blocking IPv4-to-MAC address cache

This block sits in an Ethernet transmit path and turns a 32-bit IPv4 destination into the 48-bit MAC address that the frame header needs. Lookups arrive on a valid-ready request port. Responses leave on a valid-ready response port, and they always leave in the order the lookups were accepted. A lookup that finds its address in the set-associative tag/data array is answered straight away. A lookup that misses raises a resolution request carrying the IP address. Other lookups keep flowing while the miss waits for its reply, and several misses may be outstanding at once.

Order is kept by a completion buffer. Every accepted lookup reserves the next slot. A hit fills its slot at once. A miss parks its slot number in a small content-addressable miss table keyed by IP address, because a resolution reply carries no ordering tag. When a reply arrives, its IP/MAC pair is written into the array and completes every parked slot whose IP matches. Each completion-buffer slot is a three-state machine: FREE, WAIT and DONE. Its transitions are reserve-hit (FREE to DONE), reserve-miss (FREE to WAIT), complete (WAIT to DONE) and retire (DONE to FREE, at the head, on a response handshake). Each miss-table entry is also a three-state machine: IDLE, SEND and WAIT. Its transitions are allocate-new (IDLE to SEND), allocate-duplicate (IDLE to WAIT), issued (SEND to WAIT, on a request handshake) and resolved (SEND or WAIT to IDLE, on a matching reply).

Replacement within a set uses the lowest-numbered invalid way if there is one, and otherwise the victim named by a binary-tree pseudo-LRU. The tree is updated on every hit and on every fill.

Top module: `arp_nb_cache`

## Requirements
- R1: While reset is asserted, rsp_valid and res_req_valid are low and lk_ready is high.
- R2: A lookup of an IP held in the array is answered with its MAC, with rsp_valid high in the cycle after acceptance, and raises no resolution request.
- R3: A lookup of an IP that is neither held nor pending raises a resolution request whose res_req_ip equals the lookup IP.
- R4: Responses leave in lookup acceptance order, whatever order the replies arrive in, and each response answers exactly one accepted lookup.
- R5: A miss on an IP that already has a pending miss raises no further request, and a single reply completes every pending lookup of that IP.
- R6: A reply writes its IP/MAC pair into the array, so that later lookups of that IP hit.
- R7: The array index is lk_ip[5:0] and the tag is lk_ip[31:6] (defaults: 64 sets, 4 ways). A fill first reuses the way already holding the IP. Failing that it takes the lowest-numbered invalid way. Only when every way is valid does it take the pseudo-LRU victim. Each tree node bit set to 1 steers the victim toward the upper half of its subtree, and every hit or fill sets the bits on its path to point away from the way it touched.
- R8: lk_ready is low whenever the completion buffer holds CB_DEPTH unanswered lookups or every miss-table entry is in use.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and rsp_mac stays unchanged.
- R10: While res_req_valid is high and res_req_ready is low, res_req_valid stays high and res_req_ip stays unchanged, unless a reply for that same IP arrives in that cycle.
- R11: A lookup accepted in the same cycle as a reply for the same IP is answered with the reply's MAC and raises no request.
- R12: A reply whose IP has no pending miss is still written into the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_ip | input | 32 | IPv4 address to resolve |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_mac | output | 48 | Resolved MAC address |
| res_req_valid | output | 1 | Resolution request valid |
| res_req_ready | input | 1 | Resolution request accepted |
| res_req_ip | output | 32 | IPv4 address to resolve externally |
| res_rep_valid | input | 1 | Resolution reply present (always consumed) |
| res_rep_ip | input | 32 | IPv4 address of the reply |
| res_rep_mac | input | 48 | MAC address of the reply |

## Verification
On every cycle the assertions check that both output handshakes hold steady under back-pressure, that a response never appears without an unanswered lookup behind it, that the request port stalls once CB_DEPTH lookups are unanswered, and that reset leaves both outputs quiet. Only the bench scenarios can show the values involved. These are the order of responses when replies come back reversed, the merging of duplicate misses into one request, the same-cycle reply bypass, and which way the pseudo-LRU tree evicts once a set is full, which is seen through which lookups later miss.

// File: rtl/arp_cache_pkg.sv
package arp_cache_pkg;
    localparam int IP_W  = 32;
    localparam int MAC_W = 48;

    typedef logic [IP_W-1:0]  ip_t;
    typedef logic [MAC_W-1:0] mac_t;

    // completion-buffer slot life cycle
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_DONE = 2'd2
    } slot_st_t;

    // miss-table entry life cycle
    typedef enum logic [1:0] {
        MT_IDLE = 2'd0,
        MT_SEND = 2'd1,
        MT_WAIT = 2'd2
    } mt_st_t;
endpackage

// File: rtl/arp_tag_array.sv
module arp_tag_array
    import arp_cache_pkg::*;
#(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  ip_t  lk_ip,
    input  logic touch_en,
    output logic hit,
    output mac_t hit_mac,
    input  logic fill_en,
    input  ip_t  fill_ip,
    input  mac_t fill_mac
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = IP_W - IDX_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [TREE_W-1:0] tree_t;

    logic [WAYS-1:0]  vld_q  [SETS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    mac_t             dat_q  [SETS][WAYS];
    tree_t            tree_q [SETS];

    // point every node on the path of way w away from w
    function automatic tree_t tree_touch(input tree_t t, input way_t w);
        tree_t r;
        int    wi;
        r  = t;
        wi = int'(w);
        for (int k = 0; k < TREE_W; k++) begin
            int n;
            int lv;
            int pre;
            n   = k + 1;
            lv  = $clog2(n + 1) - 1;
            pre = n - (1 << lv);
            if ((wi >> (WAY_W - lv)) == pre)
                r[k] = (((wi >> (WAY_W - 1 - lv)) & 1) == 0);
        end
        return r;
    endfunction

    // the single way whose path agrees with every node bit
    function automatic way_t tree_victim(input tree_t t);
        way_t v;
        v = '0;
        for (int w = 0; w < WAYS; w++) begin
            logic ok;
            ok = 1'b1;
            for (int lv = 0; lv < WAY_W; lv++) begin
                int n;
                int d;
                n = (1 << lv) + (w >> (WAY_W - lv));
                d = (w >> (WAY_W - 1 - lv)) & 1;
                if (int'(t[n-1]) != d)
                    ok = 1'b0;
            end
            if (ok)
                v = way_t'(w);
        end
        return v;
    endfunction

    logic [IDX_W-1:0] l_idx, f_idx;
    logic [TAG_W-1:0] l_tag, f_tag;
    way_t             hit_way, f_hit_way, f_free_way, f_way;
    logic             f_hit, f_free;
    tree_t            tree_l, tree_f_base, tree_f;

    assign l_idx = lk_ip[IDX_W-1:0];
    assign l_tag = lk_ip[IP_W-1:IDX_W];
    assign f_idx = fill_ip[IDX_W-1:0];
    assign f_tag = fill_ip[IP_W-1:IDX_W];

    // lookup compare over all ways of the indexed set
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        hit_mac = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[l_idx][w] && (tag_q[l_idx][w] == l_tag)) begin
                hit     = 1'b1;
                hit_way = way_t'(w);
                hit_mac = dat_q[l_idx][w];
            end
        end
    end

    // fill way: same IP, else lowest invalid, else tree victim
    always_comb begin
        f_hit      = 1'b0;
        f_hit_way  = '0;
        f_free     = 1'b0;
        f_free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld_q[f_idx][w] && (tag_q[f_idx][w] == f_tag)) begin
                f_hit     = 1'b1;
                f_hit_way = way_t'(w);
            end
            if (!vld_q[f_idx][w]) begin
                f_free     = 1'b1;
                f_free_way = way_t'(w);
            end
        end
        if (f_hit)
            f_way = f_hit_way;
        else if (f_free)
            f_way = f_free_way;
        else
            f_way = tree_victim(tree_q[f_idx]);
    end

    // a hit and a fill in one set compose: hit first, then fill
    always_comb begin
        tree_l      = tree_touch(tree_q[l_idx], hit_way);
        tree_f_base = (touch_en && (l_idx == f_idx)) ? tree_l : tree_q[f_idx];
        tree_f      = tree_touch(tree_f_base, f_way);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                tree_q[s] <= '0;
            end
        end else begin
            if (touch_en)
                tree_q[l_idx] <= tree_l;
            if (fill_en) begin
                tree_q[f_idx]       <= tree_f;
                vld_q[f_idx][f_way] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[f_idx][f_way] <= f_tag;
            dat_q[f_idx][f_way] <= fill_mac;
        end
    end
endmodule

// File: rtl/arp_miss_table.sv
module arp_miss_table
    import arp_cache_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ip_t              probe_ip,
    output logic             probe_pend,
    input  logic             alloc_en,
    input  logic             alloc_send,
    input  logic [$clog2(SLOTS)-1:0] alloc_slot,
    output logic             full,
    output logic             req_valid,
    input  logic             req_ready,
    output ip_t              req_ip,
    input  logic             rep_en,
    input  ip_t              rep_ip,
    output logic [SLOTS-1:0] cmpl_vec
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int IDX_W  = $clog2(DEPTH);

    mt_st_t            st_q   [DEPTH];
    mt_st_t            st_d   [DEPTH];
    ip_t               ip_q   [DEPTH];
    logic [SLOT_W-1:0] slot_q [DEPTH];
    logic              hold_q;
    logic [IDX_W-1:0]  hold_idx_q;

    logic [IDX_W-1:0]  free_idx, req_idx, send_idx;
    logic              free_any, send_any;
    logic [DEPTH-1:0]  rep_hit;

    always_comb begin
        free_any   = 1'b0;
        free_idx   = '0;
        send_any   = 1'b0;
        send_idx   = '0;
        probe_pend = 1'b0;
        cmpl_vec   = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            rep_hit[e] = rep_en && (st_q[e] != MT_IDLE) && (ip_q[e] == rep_ip);
            if (st_q[e] == MT_IDLE) begin
                free_any = 1'b1;
                free_idx = IDX_W'(e);
            end
            if (st_q[e] == MT_SEND) begin
                send_any = 1'b1;
                send_idx = IDX_W'(e);
            end
            if ((st_q[e] != MT_IDLE) && (ip_q[e] == probe_ip))
                probe_pend = 1'b1;
            if (rep_hit[e])
                cmpl_vec[slot_q[e]] = 1'b1;
        end
        full = !free_any;
        // a stalled request keeps its entry until issued or resolved
        if (hold_q) begin
            req_idx   = hold_idx_q;
            req_valid = (st_q[hold_idx_q] == MT_SEND);
        end else begin
            req_idx   = send_idx;
            req_valid = send_any;
        end
        req_ip = ip_q[req_idx];
    end

    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            st_d[e] = st_q[e];
            unique case (st_q[e])
                MT_IDLE: if (alloc_en && (free_idx == IDX_W'(e)))
                             st_d[e] = alloc_send ? MT_SEND : MT_WAIT;
                MT_SEND: if (rep_hit[e])
                             st_d[e] = MT_IDLE;
                         else if (req_valid && req_ready && (req_idx == IDX_W'(e)))
                             st_d[e] = MT_WAIT;
                MT_WAIT: if (rep_hit[e])
                             st_d[e] = MT_IDLE;
                default: st_d[e] = MT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++)
                st_q[e] <= MT_IDLE;
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++)
                st_q[e] <= st_d[e];
            hold_q     <= req_valid && !req_ready;
            hold_idx_q <= req_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                ip_q[e]   <= '0;
                slot_q[e] <= '0;
            end
        end else if (alloc_en && free_any) begin
            ip_q[free_idx]   <= probe_ip;
            slot_q[free_idx] <= alloc_slot;
        end
    end
endmodule

// File: rtl/arp_cmpl_buf.sv
module arp_cmpl_buf
    import arp_cache_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rsv_en,
    input  logic                     rsv_done,
    input  mac_t                     rsv_mac,
    output logic [$clog2(DEPTH)-1:0] rsv_slot,
    input  logic [DEPTH-1:0]         cmpl_vec,
    input  mac_t                     cmpl_mac,
    output logic                     out_valid,
    input  logic                     out_ready,
    output mac_t                     out_mac,
    output logic                     full
);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    slot_st_t          st_q  [DEPTH];
    slot_st_t          st_d  [DEPTH];
    mac_t              mac_q [DEPTH];
    logic [SLOT_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pop;

    function automatic logic [SLOT_W-1:0] ptr_inc(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign rsv_slot  = tail_q;
    assign out_valid = (st_q[head_q] == SLOT_DONE);
    assign out_mac   = mac_q[head_q];
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign pop       = out_valid && out_ready;

    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            st_d[s] = st_q[s];
            unique case (st_q[s])
                SLOT_FREE: if (rsv_en && (tail_q == SLOT_W'(s)))
                               st_d[s] = rsv_done ? SLOT_DONE : SLOT_WAIT;
                SLOT_WAIT: if (cmpl_vec[s])
                               st_d[s] = SLOT_DONE;
                SLOT_DONE: if (pop && (head_q == SLOT_W'(s)))
                               st_d[s] = SLOT_FREE;
                default:   st_d[s] = SLOT_FREE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                st_q[s]  <= SLOT_FREE;
                mac_q[s] <= '0;
            end
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                st_q[s] <= st_d[s];
                if ((st_q[s] == SLOT_FREE) && rsv_en && rsv_done && (tail_q == SLOT_W'(s)))
                    mac_q[s] <= rsv_mac;
                else if ((st_q[s] == SLOT_WAIT) && cmpl_vec[s])
                    mac_q[s] <= cmpl_mac;
            end
            if (rsv_en)
                tail_q <= ptr_inc(tail_q);
            if (pop)
                head_q <= ptr_inc(head_q);
            cnt_q <= cnt_q + CNT_W'(rsv_en) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/arp_nb_cache.sv
module arp_nb_cache
    import arp_cache_pkg::*;
#(
    parameter int SETS     = 64,
    parameter int WAYS     = 4,
    parameter int CB_DEPTH = 8,
    parameter int MT_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_valid,
    output logic        lk_ready,
    input  logic [31:0] lk_ip,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [47:0] rsp_mac,
    output logic        res_req_valid,
    input  logic        res_req_ready,
    output logic [31:0] res_req_ip,
    input  logic        res_rep_valid,
    input  logic [31:0] res_rep_ip,
    input  logic [47:0] res_rep_mac
);
    localparam int SLOT_W = $clog2(CB_DEPTH);

    logic              accept, arr_hit, bypass, is_hit;
    logic              cb_full, mt_full, pend;
    mac_t              arr_mac, hit_mac;
    logic [SLOT_W-1:0] slot;
    logic [CB_DEPTH-1:0] cmpl_vec;

    assign lk_ready = !cb_full && !mt_full;
    assign accept   = lk_valid && lk_ready;
    // a reply for the same IP in this cycle answers the lookup directly
    assign bypass   = res_rep_valid && (res_rep_ip == lk_ip);
    assign is_hit   = arr_hit || bypass;
    assign hit_mac  = bypass ? res_rep_mac : arr_mac;

    arp_tag_array #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) tags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_ip    (lk_ip),
        .touch_en (accept && arr_hit),
        .hit      (arr_hit),
        .hit_mac  (arr_mac),
        .fill_en  (res_rep_valid),
        .fill_ip  (res_rep_ip),
        .fill_mac (res_rep_mac)
    );

    arp_miss_table #(
        .DEPTH (MT_DEPTH),
        .SLOTS (CB_DEPTH)
    ) miss_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_ip   (lk_ip),
        .probe_pend (pend),
        .alloc_en   (accept && !is_hit),
        .alloc_send (!pend),
        .alloc_slot (slot),
        .full       (mt_full),
        .req_valid  (res_req_valid),
        .req_ready  (res_req_ready),
        .req_ip     (res_req_ip),
        .rep_en     (res_rep_valid),
        .rep_ip     (res_rep_ip),
        .cmpl_vec   (cmpl_vec)
    );

    arp_cmpl_buf #(
        .DEPTH (CB_DEPTH)
    ) cbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsv_en    (accept),
        .rsv_done  (is_hit),
        .rsv_mac   (hit_mac),
        .rsv_slot  (slot),
        .cmpl_vec  (cmpl_vec),
        .cmpl_mac  (res_rep_mac),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_mac   (rsp_mac),
        .full      (cb_full)
    );
endmodule

// File: rtl/arp_nb_cache_chk.sv
module arp_nb_cache_chk #(
    parameter int CB_DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic        lk_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [47:0] rsp_mac,
    input logic        res_req_valid,
    input logic        res_req_ready,
    input logic [31:0] res_req_ip,
    input logic        res_rep_valid,
    input logic [31:0] res_rep_ip
);
    localparam int CNT_W = $clog2(CB_DEPTH + 1);

    // lookups accepted but not yet answered, seen from the ports
    logic [CNT_W-1:0] open_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            open_q <= '0;
        else
            open_q <= open_q + CNT_W'(lk_valid && lk_ready) - CNT_W'(rsp_valid && rsp_ready);
    end

    always @(posedge clk) begin
        if (!rst_n)
            p_reset_quiet_r1: assert (!rsp_valid && !res_req_valid && lk_ready);
    end

    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_mac));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_req_valid && !res_req_ready && !(res_rep_valid && (res_rep_ip == res_req_ip))
        |=> res_req_valid && $stable(res_req_ip));

    p_cb_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q == CNT_W'(CB_DEPTH)) |-> !lk_ready);

    p_rsp_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (open_q != '0));
endmodule

bind arp_nb_cache arp_nb_cache_chk #(
    .CB_DEPTH (CB_DEPTH)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_ready      (lk_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_mac       (rsp_mac),
    .res_req_valid (res_req_valid),
    .res_req_ready (res_req_ready),
    .res_req_ip    (res_req_ip),
    .res_rep_valid (res_rep_valid),
    .res_rep_ip    (res_rep_ip)
);

// File: tb/arp_nb_cache_tb_top.sv
module arp_nb_cache_tb_top;
    import arp_cache_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        lk_valid, lk_ready;
    logic [31:0] lk_ip;
    logic        rsp_valid, rsp_ready;
    logic [47:0] rsp_mac;
    logic        res_req_valid, res_req_ready;
    logic [31:0] res_req_ip;
    logic        res_rep_valid;
    logic [31:0] res_rep_ip;
    logic [47:0] res_rep_mac;

    arp_nb_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_ip(lk_ip),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_mac(rsp_mac),
        .res_req_valid(res_req_valid), .res_req_ready(res_req_ready), .res_req_ip(res_req_ip),
        .res_rep_valid(res_rep_valid), .res_rep_ip(res_rep_ip), .res_rep_mac(res_rep_mac)
    );

    int   checks = 0;
    int   errors = 0;
    int   req_cnt = 0;
    int   req_base;
    bit   finished = 1'b0;
    ip_t  last_req = '0;
    mac_t exp_q[$];
    mac_t mon_exp;

    function automatic mac_t mac_of(input ip_t ip);
        return {ip[15:0] ^ 16'h5A3C, ip};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor: responses must come out in issue order
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 response with no lookup", 64'(rsp_mac), 64'h0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk(rsp_mac == mon_exp, "R4 response order/value", 64'(rsp_mac), 64'(mon_exp));
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && res_req_valid && res_req_ready) begin
            req_cnt++;
            last_req = res_req_ip;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    // driver: issue one lookup and record the MAC it must return
    task automatic lookup(input ip_t ip);
        lk_valid = 1'b1;
        lk_ip    = ip;
        do @(negedge clk); while (!lk_ready);
        exp_q.push_back(mac_of(ip));
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
    endtask

    task automatic reply(input ip_t ip);
        res_rep_valid = 1'b1;
        res_rep_ip    = ip;
        res_rep_mac   = mac_of(ip);
        step();
        res_rep_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        report();
    end

    localparam ip_t IP_A = 32'h0A00_0105;
    localparam ip_t IP_B = 32'h0A00_0211;
    localparam ip_t IP_C = 32'h0A00_0322;
    localparam ip_t IP_D = 32'h0A00_0433;
    localparam ip_t IP_F = 32'h0A00_0A2A;
    localparam ip_t IP_G = 32'h0A00_0B2B;

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_ip = '0; rsp_ready = 1'b1;
        res_req_ready = 1'b1; res_rep_valid = 1'b0; res_rep_ip = '0; res_rep_mac = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!rsp_valid, "R1 rsp_valid in reset", 64'(rsp_valid), 64'h0);
        chk(!res_req_valid, "R1 res_req_valid in reset", 64'(res_req_valid), 64'h0);
        chk(lk_ready, "R1 lk_ready in reset", 64'(lk_ready), 64'h1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);

        // R3: first miss raises a request
        lookup(IP_A);
        idle(3);
        chk(req_cnt == 1 && last_req == IP_A, "R3 miss request ip", 64'(last_req), 64'(IP_A));
        reply(IP_A);
        idle(3);

        // R2 / R6: filled entry now hits, answered next cycle
        lookup(IP_A);
        @(negedge clk);
        chk(rsp_valid && rsp_mac == mac_of(IP_A), "R2 R6 hit response next cycle", 64'(rsp_mac), 64'(mac_of(IP_A)));
        step();
        idle(2);
        chk(req_cnt == 1, "R2 hit raises no request", 64'(req_cnt), 64'd1);

        // R4: replies arrive reversed, responses stay in order
        lookup(IP_B);
        lookup(IP_A);
        lookup(IP_C);
        idle(3);
        chk(req_cnt == 3, "R3 two new misses", 64'(req_cnt), 64'd3);
        reply(IP_C);
        idle(3);
        @(negedge clk);
        chk(!rsp_valid, "R4 head waits for its reply", 64'(rsp_valid), 64'h0);
        step();
        reply(IP_B);
        idle(5);

        // R5: duplicate miss merges
        lookup(IP_D);
        lookup(IP_D);
        idle(3);
        chk(req_cnt == 4, "R5 one request for duplicate miss", 64'(req_cnt), 64'd4);
        reply(IP_D);
        idle(4);
        chk(exp_q.size() == 0, "R5 one reply completes both", 64'(exp_q.size()), 64'h0);

        // R8: miss table full
        for (int i = 0; i < 4; i++) lookup(32'h0B00_0100 + 32'(i) * 32'h41);
        @(negedge clk);
        chk(!lk_ready, "R8 miss table full stalls", 64'(lk_ready), 64'h0);
        step();
        for (int i = 3; i >= 0; i--) reply(32'h0B00_0100 + 32'(i) * 32'h41);
        idle(6);
        chk(exp_q.size() == 0, "R4 reversed replies drained", 64'(exp_q.size()), 64'h0);

        // R8 / R9: completion buffer full under back-pressure
        rsp_ready = 1'b0;
        for (int i = 0; i < 8; i++) lookup(IP_A);
        @(negedge clk);
        chk(!lk_ready, "R8 completion buffer full stalls", 64'(lk_ready), 64'h0);
        chk(rsp_valid && rsp_mac == mac_of(IP_A), "R9 response held", 64'(rsp_mac), 64'(mac_of(IP_A)));
        step();
        idle(2);
        @(negedge clk);
        chk(rsp_valid && rsp_mac == mac_of(IP_A), "R9 response still held", 64'(rsp_mac), 64'(mac_of(IP_A)));
        step();
        rsp_ready = 1'b1;
        idle(12);

        // R7 / R12: fill ways 0..3 of set 9 by unsolicited replies, touch way 0, evict
        for (int i = 0; i < 4; i++) reply({26'(i + 16), 6'd9});
        req_base = req_cnt;
        lookup({26'd16, 6'd9});
        idle(3);
        chk(req_cnt == req_base, "R12 unsolicited reply was stored", 64'(req_cnt), 64'(req_base));
        reply({26'd20, 6'd9});
        idle(2);
        lookup({26'd16, 6'd9});
        lookup({26'd17, 6'd9});
        lookup({26'd19, 6'd9});
        lookup({26'd20, 6'd9});
        idle(3);
        chk(req_cnt == req_base, "R7 touched and other ways survive", 64'(req_cnt), 64'(req_base));
        lookup({26'd18, 6'd9});
        idle(3);
        chk(req_cnt == req_base + 1 && last_req == {26'd18, 6'd9}, "R7 tree victim was way 2",
            64'(last_req), 64'({26'd18, 6'd9}));
        reply({26'd18, 6'd9});
        idle(4);

        // R11: reply and lookup of the same IP in one cycle
        req_base = req_cnt;
        lk_valid = 1'b1; lk_ip = IP_F;
        res_rep_valid = 1'b1; res_rep_ip = IP_F; res_rep_mac = mac_of(IP_F);
        @(negedge clk);
        chk(lk_ready, "R11 lookup accepted with reply", 64'(lk_ready), 64'h1);
        exp_q.push_back(mac_of(IP_F));
        step();
        lk_valid = 1'b0; res_rep_valid = 1'b0;
        idle(3);
        chk(req_cnt == req_base, "R11 bypass raises no request", 64'(req_cnt), 64'(req_base));

        // R10: stalled request holds
        res_req_ready = 1'b0;
        lookup(IP_G);
        idle(1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(res_req_valid && res_req_ip == IP_G, "R10 request held", 64'(res_req_ip), 64'(IP_G));
            step();
        end
        res_req_ready = 1'b1;
        idle(3);
        chk(last_req == IP_G, "R10 held request issued", 64'(last_req), 64'(IP_G));
        reply(IP_G);
        idle(6);

        chk(exp_q.size() == 0, "R4 every lookup answered", 64'(exp_q.size()), 64'h0);
        report();
    end
endmodule